// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry

This block shapes the second operand of a processor's arithmetic unit. It takes a word, a shift kind, a shift distance and an incoming carry flag. It returns the shifted word and a shifter carry, both registered on the next rising clock edge.

The shift kinds are logical left (also reachable under an arithmetic-left alias), logical right, sign-filling arithmetic right, rotate right, and a one-place rotate through the carry flag that forms a word-plus-one-bit ring. The distance comes from one of two sources. The first is a short immediate field that can name 0 to WIDTH-1 places. The second is the low byte of a register, which can name 0 to 255 places, so distances at and beyond the word width occur.

For a nonzero distance, the carry-out is the last bit that leaves the word. A zero distance passes the operand through unchanged, with the carry flag unchanged as well. Instruction decode, the arithmetic unit and the flag write policy are outside this block.

Top module: `barrel_carry_shifter`

## Requirements
- R1: While `rst` is high at a rising edge, `res` becomes 0 and `cout` becomes 0. Otherwise `res`/`cout` take the value computed from the inputs present at the previous rising edge, so an input change is not visible before that edge.
- R2: With `amt_sel`=0 the distance is `imm_amt` (zero-extended). With `amt_sel`=1 the distance is the 8-bit `reg_amt`. The unselected source has no effect.
- R3: For any distance of 0 and any kind other than the carry-rotate (code 4), `res` equals `opnd` and `cout` equals `cin`.
- R4: Logical left (kind code 0) fills the vacated low bits with zeros. For distance n in 1..31, `cout` = `opnd[32-n]`. For n=32, `res`=0 and `cout`=`opnd[0]`. For n>32, `res`=0 and `cout`=0.
- R5: Kind code 5 (arithmetic left) gives exactly the same `res` and `cout` as code 0 for every operand and distance.
- R6: Logical right (kind code 1) fills the vacated high bits with zeros. For n in 1..31, `cout` = `opnd[n-1]`. For n=32, `res`=0 and `cout`=`opnd[31]`. For n>32, both are 0.
- R7: Arithmetic right (kind code 2) fills the vacated high bits with `opnd[31]`. For n in 1..31, `cout` = `opnd[n-1]`. For n>=32, every bit of `res` and `cout` equal `opnd[31]`.
- R8: Rotate right (kind code 3) by nonzero n rotates by n mod 32, and `cout` = `res[31]`. A nonzero multiple of 32 returns `opnd` unchanged.
- R9: Carry-rotate (kind code 4) ignores the distance. `res` = {`cin`, `opnd[31:1]`} and `cout` = `opnd[0]`.
- R10: The unassigned kind codes 6 and 7 pass `opnd` to `res` and `cin` to `cout`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| kind | input | 3 | Shift kind code (0 left, 1 right, 2 arith right, 3 rotate, 4 carry-rotate, 5 arith left) |
| amt_sel | input | 1 | Distance source: 0 immediate, 1 register byte |
| imm_amt | input | 5 | Immediate distance, 0..31 |
| reg_amt | input | 8 | Low byte of the distance register |
| opnd | input | 32 | Operand word |
| cin | input | 1 | Incoming carry flag |
| res | output | 32 | Shifted word (registered) |
| cout | output | 1 | Shifter carry-out (registered) |

## Verification
The bench builds the block with its defaults: a 32-bit word, an 8-bit register distance and a 5-bit immediate. These defaults let the register distance reach the boundary at 31, 32 and 33 places, the far value of 255, and rotate distances of 64 and 96 that wrap to zero. A sweep of every distance from 0 to 70 for each kind, using operands with a set and a clear sign bit, compares both outputs with an arithmetic model built on 64-bit words. Separate tasks cover the alias code, the reserved codes, the choice of distance source, and carry-rotate with both values of the carry flag.

// File: rtl/shifter_pkg.sv
package shifter_pkg;

    // Shift kind codes as presented on the kind port
    typedef enum logic [2:0] {
        SK_LSL = 3'd0,
        SK_LSR = 3'd1,
        SK_ASR = 3'd2,
        SK_ROR = 3'd3,
        SK_RRX = 3'd4,
        SK_ASL = 3'd5
    } shift_kind_e;

    // Result pair carried between the core and the output stage
    typedef struct packed {
        logic        carry;
        logic [31:0] value;
    } shift_res_t;

    // Left shifts share one datapath; the alias folds onto it
    function automatic logic is_left_kind(input shift_kind_e k);
        return (k == SK_LSL) || (k == SK_ASL);
    endfunction

endpackage

// File: rtl/shift_amt_sel.sv
module shift_amt_sel #(
    parameter int SH_BITS  = 5,
    parameter int AMT_BITS = 8
) (
    input  logic                amt_sel,
    input  logic [SH_BITS-1:0]  imm_amt,
    input  logic [AMT_BITS-1:0] reg_amt,
    output logic [AMT_BITS-1:0] amt
);
    localparam int PAD = AMT_BITS - SH_BITS;

    always_comb begin
        if (amt_sel) amt = reg_amt;
        else         amt = {{PAD{1'b0}}, imm_amt};
    end
endmodule

// File: rtl/shift_rotr.sv
module shift_rotr #(
    parameter int WIDTH = 32,
    localparam int SH_BITS = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0]   din,
    input  logic [SH_BITS-1:0] k,
    output logic [WIDTH-1:0]   dout
);
    logic [WIDTH-1:0] stg [0:SH_BITS];

    assign stg[0] = din;

    // One rotate stage per bit of the distance, power-of-two steps
    for (genvar s = 0; s < SH_BITS; s++) begin : g_stage
        localparam int ROT = 2 ** s;
        assign stg[s+1] = k[s] ? {stg[s][ROT-1:0], stg[s][WIDTH-1:ROT]} : stg[s];
    end

    assign dout = stg[SH_BITS];
endmodule

// File: rtl/shift_core.sv
module shift_core
    import shifter_pkg::*;
#(
    parameter int WIDTH    = 32,
    parameter int AMT_BITS = 8,
    localparam int SH_BITS = $clog2(WIDTH)
) (
    input  shift_kind_e         kind,
    input  logic [AMT_BITS-1:0] amt,
    input  logic [WIDTH-1:0]    x,
    input  logic                cin,
    output logic [WIDTH-1:0]    y,
    output logic                cy
);
    localparam logic [AMT_BITS-1:0] FULL = AMT_BITS'(WIDTH);

    logic [SH_BITS-1:0] lo;
    logic [SH_BITS-1:0] lo_neg;
    logic [SH_BITS-1:0] idx_r;
    logic               zero_amt;
    logic               over;
    logic               exact;
    logic               sign;
    logic [WIDTH-1:0]   rot_r;
    logic [WIDTH-1:0]   rot_l;
    logic [WIDTH-1:0]   mask_r;
    logic [WIDTH-1:0]   mask_l;

    assign lo       = amt[SH_BITS-1:0];
    assign lo_neg   = ~lo + SH_BITS'(1);
    assign idx_r    = lo - SH_BITS'(1);
    assign zero_amt = (amt == '0);
    assign over     = |amt[AMT_BITS-1:SH_BITS];
    assign exact    = (amt == FULL);
    assign sign     = x[WIDTH-1];
    assign mask_r   = {WIDTH{1'b1}} >> lo;
    assign mask_l   = {WIDTH{1'b1}} << lo;

    // Right rotate by lo; left rotate by lo expressed as right by -lo
    shift_rotr #(.WIDTH(WIDTH)) u_rot_r (.din(x), .k(lo),     .dout(rot_r));
    shift_rotr #(.WIDTH(WIDTH)) u_rot_l (.din(x), .k(lo_neg), .dout(rot_l));

    always_comb begin
        y  = x;
        cy = cin;
        if (kind == SK_RRX) begin
            y  = {cin, x[WIDTH-1:1]};
            cy = x[0];
        end else if (zero_amt) begin
            y  = x;
            cy = cin;
        end else if (is_left_kind(kind)) begin
            if (!over) begin
                y  = rot_l & mask_l;
                cy = x[lo_neg];
            end else begin
                y  = '0;
                cy = exact ? x[0] : 1'b0;
            end
        end else begin
            case (kind)
                SK_LSR: begin
                    if (!over) begin
                        y  = rot_r & mask_r;
                        cy = x[idx_r];
                    end else begin
                        y  = '0;
                        cy = exact ? sign : 1'b0;
                    end
                end
                SK_ASR: begin
                    if (!over) begin
                        y  = (rot_r & mask_r) | ({WIDTH{sign}} & ~mask_r);
                        cy = x[idx_r];
                    end else begin
                        y  = {WIDTH{sign}};
                        cy = sign;
                    end
                end
                SK_ROR: begin
                    y  = rot_r;
                    cy = (lo == '0) ? sign : x[idx_r];
                end
                default: begin
                    y  = x;
                    cy = cin;
                end
            endcase
        end
    end
endmodule

// File: rtl/barrel_carry_shifter.sv
module barrel_carry_shifter
    import shifter_pkg::*;
#(
    parameter int WIDTH    = 32,
    parameter int AMT_BITS = 8,
    localparam int SH_BITS = $clog2(WIDTH)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          kind,
    input  logic                amt_sel,
    input  logic [SH_BITS-1:0]  imm_amt,
    input  logic [AMT_BITS-1:0] reg_amt,
    input  logic [WIDTH-1:0]    opnd,
    input  logic                cin,
    output logic [WIDTH-1:0]    res,
    output logic                cout
);
    logic [AMT_BITS-1:0] amt;
    logic [WIDTH-1:0]    y_c;
    logic                cy_c;
    shift_kind_e         kind_e;

    assign kind_e = shift_kind_e'(kind);

    shift_amt_sel #(.SH_BITS(SH_BITS), .AMT_BITS(AMT_BITS)) u_amt (
        .amt_sel (amt_sel),
        .imm_amt (imm_amt),
        .reg_amt (reg_amt),
        .amt     (amt)
    );

    shift_core #(.WIDTH(WIDTH), .AMT_BITS(AMT_BITS)) u_core (
        .kind (kind_e),
        .amt  (amt),
        .x    (opnd),
        .cin  (cin),
        .y    (y_c),
        .cy   (cy_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res  <= '0;
            cout <= 1'b0;
        end else begin
            res  <= y_c;
            cout <= cy_c;
        end
    end

    AST_REG_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
        (amt_sel && reg_amt == '0 && kind == 3'd0) |=> (res == $past(opnd) && cout == $past(cin))); // R2

    AST_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
        (amt == '0 && kind != 3'd4) |=> (res == $past(opnd) && cout == $past(cin))); // R3

    AST_LSL_FAR: assert property (@(posedge clk) disable iff (rst)
        (kind == 3'd0 && amt > AMT_BITS'(WIDTH)) |=> (res == '0 && !cout)); // R4

    AST_ASR_FAR: assert property (@(posedge clk) disable iff (rst)
        (kind == 3'd2 && amt >= AMT_BITS'(WIDTH)) |=> (res == {WIDTH{$past(opnd[WIDTH-1])}} && cout == $past(opnd[WIDTH-1]))); // R7

    AST_ROR_FULL: assert property (@(posedge clk) disable iff (rst)
        (kind == 3'd3 && amt == AMT_BITS'(WIDTH)) |=> (res == $past(opnd) && cout == $past(opnd[WIDTH-1]))); // R8

    AST_RRX_RING: assert property (@(posedge clk) disable iff (rst)
        (kind == 3'd4) |=> (res == {$past(cin), $past(opnd[WIDTH-1:1])} && cout == $past(opnd[0]))); // R9
endmodule

// File: tb/test_barrel_carry_shifter.sv
module test_barrel_carry_shifter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  kind = 3'd0;
    logic        amt_sel = 1'b0;
    logic [4:0]  imm_amt = 5'd0;
    logic [7:0]  reg_amt = 8'd0;
    logic [31:0] opnd = 32'h0;
    logic        cin = 1'b0;
    logic [31:0] res;
    logic        cout;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    barrel_carry_shifter i_barrel_carry_shifter (
        .clk(clk), .rst(rst), .kind(kind), .amt_sel(amt_sel),
        .imm_amt(imm_amt), .reg_amt(reg_amt), .opnd(opnd), .cin(cin),
        .res(res), .cout(cout)
    );

    // Arithmetic model on 64-bit words: {carry, value}
    function automatic logic [32:0] model(input logic [2:0] k, input int n,
                                          input logic [31:0] x, input logic c);
        logic [63:0]        t;
        logic signed [63:0] ts;
        logic [31:0]        r;
        int                 m;
        if (k == 3'd4) return {x[0], c, x[31:1]};
        if (k > 3'd5 || n == 0) return {c, x};
        case (k)
            3'd0, 3'd5: begin
                if (n >= 64) return 33'h0;
                t = {32'h0, x} << n;
                return {t[32], t[31:0]};
            end
            3'd1: begin
                if (n >= 64) return 33'h0;
                t = {x, 32'h0} >> n;
                return {t[31], t[63:32]};
            end
            3'd2: begin
                m = (n > 63) ? 63 : n;
                ts = $signed({x, 32'h0}) >>> m;
                return {ts[31], ts[63:32]};
            end
            default: begin
                m = n % 32;
                r = (m == 0) ? x : ((x >> m) | (x << (32 - m)));
                return {r[31], r};
            end
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] exp_v, input logic exp_c);
        checks++;
        if (res !== exp_v || cout !== exp_c) begin
            failures++;
            $display("FAIL %s: res=%h cout=%b expected res=%h cout=%b",
                     req, res, cout, exp_v, exp_c);
        end
    endtask

    task automatic apply(input string req, input logic [2:0] k, input logic sel,
                         input logic [4:0] imm, input logic [7:0] rv,
                         input logic [31:0] x, input logic c);
        logic [32:0] e;
        int n;
        @(negedge clk);
        kind = k; amt_sel = sel; imm_amt = imm; reg_amt = rv; opnd = x; cin = c;
        n = sel ? int'(rv) : int'(imm);
        e = model(k, n, x, c);
        @(negedge clk);
        check(req, e[31:0], e[32]);
    endtask

    task automatic t_reset();
        @(negedge clk);
        kind = 3'd4; opnd = 32'hFFFF_FFFF; cin = 1'b1; rst = 1'b1;
        @(negedge clk);
        check("R1 reset clears", 32'h0, 1'b0);
        rst = 1'b0;
        #1 check("R1 no change before edge", 32'h0, 1'b0);
        @(negedge clk);
        check("R1 registered after edge", 32'hFFFF_FFFF, 1'b1);
    endtask

    task automatic t_source();
        apply("R2 imm used", 3'd0, 1'b0, 5'd4, 8'd9, 32'h0000_00F1, 1'b0);
        check("R2 imm value", 32'h0000_0F10, 1'b0);
        apply("R2 reg used", 3'd1, 1'b1, 5'd3, 8'd8, 32'hA500_1234, 1'b0);
        check("R2 reg value", 32'h00A5_0012, 1'b0);
        apply("R2 reg zero ignores imm", 3'd0, 1'b1, 5'd7, 8'd0, 32'h1234_5678, 1'b1);
        check("R2 pass", 32'h1234_5678, 1'b1);
    endtask

    task automatic t_zero();
        for (int k = 0; k < 4; k++) begin
            apply("R3 zero amount", 3'(k), 1'b0, 5'd0, 8'd0, 32'h8765_4321, 1'b1);
            check("R3 zero pass", 32'h8765_4321, 1'b1);
        end
    endtask

    task automatic t_lsl();
        apply("R4 lsl 1", 3'd0, 1'b0, 5'd1, 8'd0, 32'h8000_0001, 1'b0);
        check("R4 lsl 1 value", 32'h0000_0002, 1'b1);
        apply("R4 lsl 32", 3'd0, 1'b1, 5'd0, 8'd32, 32'h0000_0001, 1'b0);
        check("R4 lsl 32 value", 32'h0, 1'b1);
        apply("R4 lsl 33", 3'd0, 1'b1, 5'd0, 8'd33, 32'hFFFF_FFFF, 1'b1);
        check("R4 lsl 33 value", 32'h0, 1'b0);
    endtask

    task automatic t_asl();
        for (int n = 0; n < 40; n += 3) begin
            apply("R5 asl alias", 3'd5, 1'b1, 5'd0, 8'(n), 32'hC3A5_5A3C, 1'b1);
        end
    endtask

    task automatic t_lsr();
        apply("R6 lsr 32", 3'd1, 1'b1, 5'd0, 8'd32, 32'h8000_0000, 1'b0);
        check("R6 lsr 32 value", 32'h0, 1'b1);
        apply("R6 lsr 255", 3'd1, 1'b1, 5'd0, 8'd255, 32'hFFFF_FFFF, 1'b1);
        check("R6 lsr 255 value", 32'h0, 1'b0);
    endtask

    task automatic t_asr();
        apply("R7 asr neg", 3'd2, 1'b0, 5'd4, 8'd0, 32'h8000_0010, 1'b0);
        check("R7 asr neg value", 32'hF800_0001, 1'b0);
        apply("R7 asr pos", 3'd2, 1'b0, 5'd3, 8'd0, 32'h4000_0004, 1'b0);
        check("R7 asr pos value", 32'h0800_0000, 1'b1);
        apply("R7 asr 200", 3'd2, 1'b1, 5'd0, 8'd200, 32'h8000_0000, 1'b0);
        check("R7 asr 200 value", 32'hFFFF_FFFF, 1'b1);
    endtask

    task automatic t_ror();
        apply("R8 ror 4", 3'd3, 1'b0, 5'd4, 8'd0, 32'h1234_5678, 1'b0);
        check("R8 ror 4 value", 32'h8123_4567, 1'b1);
        apply("R8 ror 32", 3'd3, 1'b1, 5'd0, 8'd32, 32'h9ABC_DEF0, 1'b0);
        check("R8 ror 32 value", 32'h9ABC_DEF0, 1'b1);
        apply("R8 ror 64", 3'd3, 1'b1, 5'd0, 8'd64, 32'h1ABC_DEF0, 1'b1);
        check("R8 ror 64 value", 32'h1ABC_DEF0, 1'b0);
        apply("R8 ror 36", 3'd3, 1'b1, 5'd0, 8'd36, 32'h0000_000F, 1'b0);
        check("R8 ror 36 value", 32'hF000_0000, 1'b1);
    endtask

    task automatic t_rrx();
        apply("R9 rrx cin1", 3'd4, 1'b0, 5'd7, 8'd0, 32'h0000_0003, 1'b1);
        check("R9 rrx cin1 value", 32'h8000_0001, 1'b1);
        apply("R9 rrx cin0", 3'd4, 1'b1, 5'd0, 8'd90, 32'h8000_0002, 1'b0);
        check("R9 rrx cin0 value", 32'h4000_0001, 1'b0);
    endtask

    task automatic t_reserved();
        apply("R10 code 6", 3'd6, 1'b0, 5'd5, 8'd0, 32'hDEAD_BEEF, 1'b1);
        check("R10 code 6 value", 32'hDEAD_BEEF, 1'b1);
        apply("R10 code 7", 3'd7, 1'b1, 5'd0, 8'd40, 32'h0BAD_F00D, 1'b0);
        check("R10 code 7 value", 32'h0BAD_F00D, 1'b0);
    endtask

    task automatic t_sweep();
        for (int k = 0; k < 4; k++) begin
            for (int n = 0; n <= 70; n++) begin
                apply("R4 R6 R7 R8 sweep", 3'(k), 1'b1, 5'd0, 8'(n), 32'hB1C3_5E27, n[0]);
                apply("R4 R6 R7 R8 sweep", 3'(k), 1'b1, 5'd0, 8'(n), 32'h6D2F_0A91, n[1]);
            end
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: res=%h cout=%b expected completion", res, cout);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_source();
        t_zero();
        t_lsl();
        t_asl();
        t_lsr();
        t_asr();
        t_ror();
        t_rrx();
        t_reserved();
        t_sweep();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule